// File: doc/BRIEF.md
# Rank Interleave and DRAM Coordinate Mapper

This block takes an address that is already local to one memory channel and turns it into the physical coordinates of a DRAM access: the DIMM slot, the rank on that DIMM, the address within the rank, and the row, column, bank and bank group. It scans a small table of rank-interleave range entries to find the one that covers the address. It removes the rank-way interleave at a bit position set by the page policy. It then looks up a per-way interleave word that supplies the channel rank and an offset to subtract.

The rank address is then mapped to DRAM coordinates. Row and column bits are picked from scattered rank-address bits through fixed tables. Closed-page and open-page policies use different tables, and open page has a separate column table for fine-grain banking. Bank and bank-group indices come from fixed bit pairs and can be XOR-hashed with higher address bits. The per-DIMM configuration (page policy, fine-grain bank, XOR hashing, row width, column width) arrives as plain inputs.

A request is a one-cycle `start` pulse. All results are registered and appear on the cycle after `start`, marked by a one-cycle `done` pulse. The results hold until the next request.

Top module: `rank_dram_mapper`

## Requirements
- R1: Entry i of `rir_way` (bits 32i+31:32i) is valid when its bit 31 is set. Its upper bound is bits 11:1 placed at address bit 29 and up, with address bits 28:0 all ones. The lower bound of entry 0 is zero, and the lower bound of entry i+1 equals the upper bound of entry i, whether or not entry i is valid. The lowest-numbered valid entry whose lower bound ≤ address ≤ upper bound is selected.
- R2: When no valid entry matches, `fail` is 1 with `done`, and `dimm`, `rank`, `rank_addr`, `row`, `column`, `bank` and `bank_group` are all zero.
- R3: The interleave shift s is 6 when `close_pg`=1 and 13 when `close_pg`=0. The way count W is 1 shifted left by bits 29:28 of the selected entry. The de-interleaved address is ((addr >> s) / W) << s, with the low s bits of addr kept.
- R4: The way index is (addr >> s) mod W. It selects word 8·e + way of `rir_ilv` (bits 32k+31:32k), where e is the entry number. That word's bits 15:2, placed at address bit 26, are subtracted from the de-interleaved address to form `rank_addr`, modulo 2^ADDR_W.
- R5: The channel rank is bits 19:16 of the selected interleave word. `dimm` is the channel rank divided by 4, and `rank` is the channel rank mod 4.
- R6: In closed page, row bit i is `rank_addr` bit number i of the list 15,16,17,18,20,21,22,28,10,11,12,13,29,30,31,32,33. Column bit i is bit number i of the list 3,4,5,14,19,23,24,25,26,27. `column` bit 10 is always 1.
- R7: In open page, row bit i comes from bit number i of the list 14,15,16,20,28,21,22,23,24,25,26,27,29,30,31,32,33. Column bit i comes from bit 3+i when `fine_bank`=0, and from bit number i of the list 3,4,5,7,8,9,10,11,12,13 when `fine_bank`=1. `column` bit 10 is 0.
- R8: `bank` is {ra[9],ra[8]} in closed page and {ra[19],ra[18]} in open page. `bank_group` is {ra[7],ra[6]} in closed page and {ra[17], fine_bank ? ra[6] : ra[13]} in open page. With `bank_xor`=1, `bank` is XORed with {ra[28],ra[22]} in closed page or {ra[23],ra[22]} in open page, and `bank_group` is XORed with {ra[21],ra[20]}.
- R9: Only row bits below `row_bits` and column bits below `col_bits` are gathered. Higher row bits and gathered-column positions are zero.
- R10: `done` is 1 exactly on the cycle after `start`. Without `start`, every result output keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse; inputs are sampled in this cycle |
| chan_addr | input | ADDR_W | Channel-local address |
| rir_way | input | N_ENT*32 | Rank-interleave range entries |
| rir_ilv | input | N_ENT*8*32 | Per-entry, per-way interleave words |
| close_pg | input | 1 | 1 = closed-page policy, 0 = open page |
| fine_bank | input | 1 | Fine-grain bank mapping enable |
| bank_xor | input | 1 | Bank and bank-group XOR hashing enable |
| row_bits | input | 5 | Number of row bits |
| col_bits | input | 4 | Number of gathered column bits |
| done | output | 1 | One-cycle result strobe |
| fail | output | 1 | No matching entry |
| dimm | output | 2 | DIMM slot |
| rank | output | 2 | Rank on DIMM |
| rank_addr | output | ADDR_W | Address within the rank |
| row | output | 17 | Row |
| column | output | 11 | Column |
| bank | output | 2 | Bank |
| bank_group | output | 2 | Bank group |

## Verification
Directed cases place the address exactly on an entry's upper bound, just above it, and on a bound shared with an invalid entry below. These separate an inclusive lower bound from a "limit plus one" bound and show first-match priority. Other directed cases put the address above every limit to exercise the failure path. They also try every page policy, fine-grain and XOR combination, so a swapped table or hash pair shows up on its own. Random requests vary the way counts (1 to 8), the interleave words, and the row and column widths, which covers the division, the modulo way selection, the offset subtraction and the width masking over many bit patterns.

// File: rtl/rdm_pkg.sv
package rdm_pkg;
    localparam int RDM_ROW_W = 17;
    localparam int RDM_COLG_W = 10;
    localparam int RDM_COL_W = RDM_COLG_W + 1;

    localparam int CP_ROW [RDM_ROW_W] =
        '{15, 16, 17, 18, 20, 21, 22, 28, 10, 11, 12, 13, 29, 30, 31, 32, 33};
    localparam int CP_COL [RDM_COLG_W] =
        '{3, 4, 5, 14, 19, 23, 24, 25, 26, 27};
    localparam int OP_ROW [RDM_ROW_W] =
        '{14, 15, 16, 20, 28, 21, 22, 23, 24, 25, 26, 27, 29, 30, 31, 32, 33};
    localparam int OP_COL [RDM_COLG_W] =
        '{3, 4, 5, 6, 7, 8, 9, 10, 11, 12};
    localparam int OP_FCOL [RDM_COLG_W] =
        '{3, 4, 5, 7, 8, 9, 10, 11, 12, 13};
endpackage

// File: rtl/rdm_rir_scan.sv
module rdm_rir_scan #(
    parameter int N_ENT  = 4,
    parameter int ADDR_W = 40,
    localparam int ENT_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic [N_ENT*32-1:0] way_words,
    input  logic [ADDR_W-1:0]   addr,
    output logic                hit,
    output logic [ENT_W-1:0]    ent,
    output logic [1:0]          ways_log2
);
    always_comb begin
        logic [31:0]       w;
        logic [ADDR_W-1:0] lim;
        logic [ADDR_W-1:0] lower;
        hit       = 1'b0;
        ent       = '0;
        ways_log2 = 2'd0;
        lower     = '0;
        for (int i = 0; i < N_ENT; i++) begin
            w   = way_words[i*32 +: 32];
            lim = ADDR_W'({w[11:1], {29{1'b1}}});
            if (!hit && w[31] && addr >= lower && addr <= lim) begin
                hit       = 1'b1;
                ent       = ENT_W'(i);
                ways_log2 = w[29:28];
            end
            lower = lim;
        end
    end
endmodule

// File: rtl/rdm_rank_split.sv
module rdm_rank_split #(
    parameter int N_ENT    = 4,
    parameter int MAX_WAYS = 8,
    parameter int ADDR_W   = 40,
    localparam int ENT_W = (N_ENT > 1) ? $clog2(N_ENT) : 1,
    localparam int WAY_W = $clog2(MAX_WAYS)
) (
    input  logic [ADDR_W-1:0]            addr,
    input  logic                         close_pg,
    input  logic [ENT_W-1:0]             ent,
    input  logic [1:0]                   ways_log2,
    input  logic [N_ENT*MAX_WAYS*32-1:0] ilv_words,
    output logic [ADDR_W-1:0]            rank_addr,
    output logic [3:0]                   chan_rank
);
    always_comb begin
        int                unsigned sh;
        logic [ADDR_W-1:0] upper;
        logic [ADDR_W-1:0] quot;
        logic [ADDR_W-1:0] low_mask;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] offset;
        logic [WAY_W-1:0]  way;
        logic [31:0]       w;
        int                unsigned idx;
        sh       = close_pg ? 32'd6 : 32'd13;
        upper    = addr >> sh;
        quot     = upper >> ways_log2;
        way      = WAY_W'(upper) & WAY_W'((1 << ways_log2) - 1);
        low_mask = (ADDR_W'(1) << sh) - ADDR_W'(1);
        base     = (quot << sh) | (addr & low_mask);
        idx      = 32'(ent) * MAX_WAYS + 32'(way);
        w        = ilv_words[idx*32 +: 32];
        offset   = ADDR_W'({w[15:2], 26'b0});
        rank_addr = base - offset;
        chan_rank = w[19:16];
    end
endmodule

// File: rtl/rdm_dram_gather.sv
module rdm_dram_gather
    import rdm_pkg::*;
#(
    parameter int ADDR_W = 40
) (
    input  logic [ADDR_W-1:0]    ra,
    input  logic                 close_pg,
    input  logic                 fine_bank,
    input  logic                 bank_xor,
    input  logic [4:0]           row_bits,
    input  logic [3:0]           col_bits,
    output logic [RDM_ROW_W-1:0] row,
    output logic [RDM_COL_W-1:0] column,
    output logic [1:0]           bank,
    output logic [1:0]           bank_group
);
    always_comb begin
        logic [1:0] bk_hash;
        logic [1:0] bg_hash;
        row    = '0;
        column = '0;
        for (int i = 0; i < RDM_ROW_W; i++) begin
            if (i < int'(row_bits))
                row[i] = close_pg ? ra[CP_ROW[i]] : ra[OP_ROW[i]];
        end
        for (int i = 0; i < RDM_COLG_W; i++) begin
            if (i < int'(col_bits))
                column[i] = close_pg  ? ra[CP_COL[i]] :
                            fine_bank ? ra[OP_FCOL[i]] : ra[OP_COL[i]];
        end
        column[RDM_COL_W-1] = close_pg;
        if (close_pg) begin
            bank       = {ra[9], ra[8]};
            bank_group = {ra[7], ra[6]};
            bk_hash    = {ra[28], ra[22]};
        end else begin
            bank       = {ra[19], ra[18]};
            bank_group = {ra[17], fine_bank ? ra[6] : ra[13]};
            bk_hash    = {ra[23], ra[22]};
        end
        bg_hash = {ra[21], ra[20]};
        if (bank_xor) begin
            bank       = bank ^ bk_hash;
            bank_group = bank_group ^ bg_hash;
        end
    end
endmodule

// File: rtl/rank_dram_mapper.sv
module rank_dram_mapper
    import rdm_pkg::*;
#(
    parameter int N_ENT    = 4,
    parameter int MAX_WAYS = 8,
    parameter int ADDR_W   = 40,
    localparam int ENT_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [ADDR_W-1:0]            chan_addr,
    input  logic [N_ENT*32-1:0]          rir_way,
    input  logic [N_ENT*MAX_WAYS*32-1:0] rir_ilv,
    input  logic                         close_pg,
    input  logic                         fine_bank,
    input  logic                         bank_xor,
    input  logic [4:0]                   row_bits,
    input  logic [3:0]                   col_bits,
    output logic                         done,
    output logic                         fail,
    output logic [1:0]                   dimm,
    output logic [1:0]                   rank,
    output logic [ADDR_W-1:0]            rank_addr,
    output logic [RDM_ROW_W-1:0]         row,
    output logic [RDM_COL_W-1:0]         column,
    output logic [1:0]                   bank,
    output logic [1:0]                   bank_group
);
    typedef struct packed {
        logic                 done;
        logic                 fail;
        logic [1:0]           dimm;
        logic [1:0]           rank;
        logic [ADDR_W-1:0]    rank_addr;
        logic [RDM_ROW_W-1:0] row;
        logic [RDM_COL_W-1:0] column;
        logic [1:0]           bank;
        logic [1:0]           bank_group;
    } map_state_t;

    map_state_t st_d, st_q;

    logic                 hit_w;
    logic [ENT_W-1:0]     ent_w;
    logic [1:0]           wl_w;
    logic [ADDR_W-1:0]    ra_w;
    logic [3:0]           crank_w;
    logic [RDM_ROW_W-1:0] row_w;
    logic [RDM_COL_W-1:0] col_w;
    logic [1:0]           bank_w, bg_w;

    rdm_rir_scan #(.N_ENT(N_ENT), .ADDR_W(ADDR_W)) u_scan (
        .way_words (rir_way),
        .addr      (chan_addr),
        .hit       (hit_w),
        .ent       (ent_w),
        .ways_log2 (wl_w)
    );

    rdm_rank_split #(.N_ENT(N_ENT), .MAX_WAYS(MAX_WAYS), .ADDR_W(ADDR_W)) u_split (
        .addr      (chan_addr),
        .close_pg  (close_pg),
        .ent       (ent_w),
        .ways_log2 (wl_w),
        .ilv_words (rir_ilv),
        .rank_addr (ra_w),
        .chan_rank (crank_w)
    );

    rdm_dram_gather #(.ADDR_W(ADDR_W)) u_gather (
        .ra         (ra_w),
        .close_pg   (close_pg),
        .fine_bank  (fine_bank),
        .bank_xor   (bank_xor),
        .row_bits   (row_bits),
        .col_bits   (col_bits),
        .row        (row_w),
        .column     (col_w),
        .bank       (bank_w),
        .bank_group (bg_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start) begin
            st_d      = '0;
            st_d.done = 1'b1;
            if (!hit_w) begin
                st_d.fail = 1'b1;
            end else begin
                st_d.dimm       = crank_w[3:2];
                st_d.rank       = crank_w[1:0];
                st_d.rank_addr  = ra_w;
                st_d.row        = row_w;
                st_d.column     = col_w;
                st_d.bank       = bank_w;
                st_d.bank_group = bg_w;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done       = st_q.done;
    assign fail       = st_q.fail;
    assign dimm       = st_q.dimm;
    assign rank       = st_q.rank;
    assign rank_addr  = st_q.rank_addr;
    assign row        = st_q.row;
    assign column     = st_q.column;
    assign bank       = st_q.bank;
    assign bank_group = st_q.bank_group;

    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done); // R10
    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done); // R10
    AST_HOLD_RESULTS: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(rank_addr) && $stable(row) && $stable(column) && $stable(fail))); // R10
    AST_FAIL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (rank_addr == '0 && row == '0 && column == '0 && dimm == 2'd0)); // R2
    AST_CLOSED_COL10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fail && $past(close_pg)) |-> column[RDM_COL_W-1]); // R6
    AST_ROW_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fail) |-> ((row >> $past(row_bits)) == '0)); // R9
endmodule

// File: tb/rank_dram_mapper_bench.sv
`timescale 1ns/1ps
module rank_dram_mapper_bench;
    localparam int N_ENT = 4;
    localparam int MW    = 8;
    localparam int AW    = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [AW-1:0] chan_addr = '0;
    logic [N_ENT*32-1:0] rir_way = '0;
    logic [N_ENT*MW*32-1:0] rir_ilv = '0;
    logic close_pg = 1'b0, fine_bank = 1'b0, bank_xor = 1'b0;
    logic [4:0] row_bits = 5'd17;
    logic [3:0] col_bits = 4'd10;
    logic done, fail;
    logic [1:0] dimm, rank, bank, bank_group;
    logic [AW-1:0] rank_addr;
    logic [16:0] row;
    logic [10:0] column;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    rank_dram_mapper u_rank_dram_mapper (
        .clk(clk), .rst_n(rst_n), .start(start), .chan_addr(chan_addr),
        .rir_way(rir_way), .rir_ilv(rir_ilv), .close_pg(close_pg),
        .fine_bank(fine_bank), .bank_xor(bank_xor), .row_bits(row_bits),
        .col_bits(col_bits), .done(done), .fail(fail), .dimm(dimm),
        .rank(rank), .rank_addr(rank_addr), .row(row), .column(column),
        .bank(bank), .bank_group(bank_group)
    );

    localparam int T_CROW [17] = '{15,16,17,18,20,21,22,28,10,11,12,13,29,30,31,32,33};
    localparam int T_CCOL [10] = '{3,4,5,14,19,23,24,25,26,27};
    localparam int T_OROW [17] = '{14,15,16,20,28,21,22,23,24,25,26,27,29,30,31,32,33};
    localparam int T_FCOL [10] = '{3,4,5,7,8,9,10,11,12,13};

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic longint bitof(input longint v, input int p);
        return (v >> p) & 64'd1;
    endfunction

    task automatic set_entry(input int e, input bit vld, input int lim_f, input int wl);
        logic [31:0] w;
        w = '0;
        w[31] = vld;
        w[29:28] = 2'(wl);
        w[11:1] = 11'(lim_f);
        rir_way[e*32 +: 32] = w;
    endtask

    task automatic run_case(input logic [AW-1:0] a);
        longint mask40, lower, lim, up, ways, q, way, ra, base, off, crank;
        longint erow, ecol, ebk, ebg, h;
        int sel, sh;
        logic [31:0] w, iw;
        bit efail;
        mask40 = (64'd1 << AW) - 1;
        sel = -1; lower = 0; ways = 1;
        for (int i = 0; i < N_ENT; i++) begin
            w = rir_way[i*32 +: 32];
            lim = (longint'(w[11:1]) << 29) | 64'h1FFFFFFF;
            if (sel < 0 && w[31] && longint'(a) >= lower && longint'(a) <= lim) begin
                sel = i;
                ways = 64'd1 << w[29:28];
            end
            lower = lim;
        end
        efail = (sel < 0);
        sh = close_pg ? 6 : 13;
        up = longint'(a) >> sh;
        q = up / ways;
        way = up % ways;
        base = (q << sh) | (longint'(a) % (64'd1 << sh));
        iw = efail ? 32'd0 : rir_ilv[(sel*MW + int'(way))*32 +: 32];
        off = longint'(iw[15:2]) << 26;
        ra = (base - off) & mask40;
        crank = longint'(iw[19:16]);
        erow = 0; ecol = 0;
        for (int i = 0; i < int'(row_bits) && i < 17; i++)
            erow |= bitof(ra, close_pg ? T_CROW[i] : T_OROW[i]) << i;
        for (int i = 0; i < int'(col_bits) && i < 10; i++)
            ecol |= bitof(ra, close_pg ? T_CCOL[i] : (fine_bank ? T_FCOL[i] : 3 + i)) << i;
        if (close_pg) ecol |= 64'h400;
        if (close_pg) begin
            ebk = bitof(ra, 8) | (bitof(ra, 9) << 1);
            ebg = bitof(ra, 6) | (bitof(ra, 7) << 1);
            h = bitof(ra, 22) | (bitof(ra, 28) << 1);
        end else begin
            ebk = bitof(ra, 18) | (bitof(ra, 19) << 1);
            ebg = bitof(ra, fine_bank ? 6 : 13) | (bitof(ra, 17) << 1);
            h = bitof(ra, 22) | (bitof(ra, 23) << 1);
        end
        if (bank_xor) begin
            ebk ^= h;
            ebg ^= bitof(ra, 20) | (bitof(ra, 21) << 1);
        end
        if (efail) begin
            ra = 0; crank = 0; erow = 0; ecol = 0; ebk = 0; ebg = 0;
        end
        chan_addr = a;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R10 done", longint'(done), 1);
        chk("R1/R2 fail", longint'(fail), longint'(efail));
        chk("R3/R4 rank_addr", longint'(rank_addr), ra);
        chk("R5 dimm", longint'(dimm), crank >> 2);
        chk("R5 rank", longint'(rank), crank & 3);
        chk(close_pg ? "R6/R9 row" : "R7/R9 row", longint'(row), erow);
        chk(close_pg ? "R6/R9 column" : "R7/R9 column", longint'(column), ecol);
        chk("R8 bank", longint'(bank), ebk);
        chk("R8 bank_group", longint'(bank_group), ebg);
        chan_addr = ~a;
        @(negedge clk);
        chk("R10 done low", longint'(done), 0);
        chk("R10 hold rank_addr", longint'(rank_addr), ra);
        chk("R10 hold row", longint'(row), erow);
    endtask

    task automatic rand_ilv();
        for (int k = 0; k < N_ENT*MW; k++) rir_ilv[k*32 +: 32] = $urandom;
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        repeat (2) @(negedge clk);
        chk("R10 reset done", longint'(done), 0);
        chk("R2 reset fail", longint'(fail), 0);
        chk("R10 reset rank_addr", longint'(rank_addr), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: inclusive upper bound, lower bound shared with previous limit
        rand_ilv();
        close_pg = 1'b1; fine_bank = 1'b0; bank_xor = 1'b0;
        set_entry(0, 1, 1, 0); set_entry(1, 1, 3, 1);
        set_entry(2, 1, 6, 2); set_entry(3, 1, 9, 3);
        run_case(40'h0_3FFF_FFFF);
        run_case(40'h0_4000_0000);
        run_case(40'h0_7FFF_FFFF);
        set_entry(0, 0, 1, 0);
        run_case(40'h0_3FFF_FFFF);
        run_case(40'h0_0000_1234);
        // R2: above every limit, then all invalid
        run_case(40'h1_4000_0000);
        rir_way = '0;
        run_case(40'h0_0000_0040);
        // R7/R8 open-page variants
        set_entry(0, 1, 2, 1); set_entry(1, 1, 5, 3);
        set_entry(2, 0, 7, 0); set_entry(3, 1, 12, 2);
        for (int m = 0; m < 8; m++) begin
            close_pg = m[0]; fine_bank = m[1]; bank_xor = m[2];
            run_case(40'h0_5A5A_5A5A);
            run_case(40'h1_2345_6789);
        end
        // R9: narrow row/col widths
        row_bits = 5'd12; col_bits = 4'd7;
        run_case(40'h1_FFFF_FFFF);
        row_bits = 5'd0; col_bits = 4'd0;
        run_case(40'h0_FFFF_FFFF);

        for (int n = 0; n < 400; n++) begin
            int f0, f1, f2, f3;
            rand_ilv();
            f0 = 1 + int'($urandom_range(0, 3));
            f1 = f0 + int'($urandom_range(0, 4));
            f2 = f1 + 1 + int'($urandom_range(0, 4));
            f3 = f2 + 1 + int'($urandom_range(0, 4));
            set_entry(0, $urandom_range(0, 7) != 0, f0, int'($urandom_range(0, 3)));
            set_entry(1, $urandom_range(0, 7) != 0, f1, int'($urandom_range(0, 3)));
            set_entry(2, $urandom_range(0, 7) != 0, f2, int'($urandom_range(0, 3)));
            set_entry(3, $urandom_range(0, 7) != 0, f3, int'($urandom_range(0, 3)));
            close_pg = 1'($urandom); fine_bank = 1'($urandom); bank_xor = 1'($urandom);
            row_bits = 5'($urandom_range(10, 17));
            col_bits = 4'($urandom_range(6, 10));
            run_case({6'd0, 34'($urandom_range(0, 32'hFFFF_FFFF)) +
                      (34'($urandom_range(0, 3)) << 32)});
        end

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule